// File: doc/BRIEF.md
# Masked BCD Time-of-Day Alarm Comparator with Status Flags

This block watches a live BCD time of day (seconds, minutes, hours) that another block counts, and compares it with one programmable alarm register per time field. Each alarm register holds an ignore bit, so an alarm can fire, for example, every hour at a given minute, or every day at a given time. The comparison is made once per second-strobe. The alarm flag is raised only in the second in which a match begins.

Next to the alarm registers sits an 8-bit status register. It holds sticky event flags for watchdog expiry, alarm, power failure and oscillator failure, plus three mode bits: calibration output enable, write enable and read enable. Reading the status register over the simple register bus clears the watchdog, alarm and power-fail flags. The oscillator-fail flag is retained across resets and is cleared only by software. The interrupt pin reports pending events. When calibration mode is on, the pin instead carries a square wave made by toggling on each pulse of a 512 Hz enable input.

Top module: `tod_alarm_status`

## Requirements
- R1: The alarm registers sit at bus addresses 0 (seconds), 1 (minutes) and 2 (hours). In each, bit 7 is the ignore bit, bits 6:4 are the tens digit and bits 3:0 are the units digit. A write stores all 8 bits. A read returns them. Reset sets all three to 0x00.
- R2: A field takes part in the match when its ignore bit is 0. It then requires bits 6:0 of the alarm register to equal bits 6:0 of the time field. A field whose ignore bit is 1 always matches. The alarm matches when all fields match.
- R3: The match is evaluated only in cycles where `tick_i` is high. The alarm flag (status bit 6) is set at the clock edge that samples such a cycle, provided the match holds and the match was false at the previous tick (or no tick has occurred since reset). The alarm flag never rises after a cycle without a tick.
- R4: The status register is at address 3 and is laid out as follows: bit 7 watchdog flag, bit 6 alarm flag, bit 5 power-fail flag, bit 4 oscillator-fail flag, bit 3 always reads 0, bit 2 calibration enable, bit 1 write enable, bit 0 read enable. A status write stores bits 2:0 and has no effect on bits 7:5 or bit 3.
- R5: A one-cycle pulse on `wdog_expire_i` or `pwr_fail_i` sets status bit 7 or bit 5 at the next edge. The flag then stays set until it is cleared.
- R6: A read of address 3 returns the status value from before the read. At the next edge it clears bits 7, 6 and 5. If an event for a flag arrives in the same cycle as the read, that flag ends up set.
- R7: Status bit 4 is set at every edge where `osc_fail_i` is high. It is cleared only by a status write with bit 4 = 0 while `osc_fail_i` is low. Writing 1 to bit 4 has no effect, and `rst_n` does not change the bit.
- R8: Asserting `rst_n` low clears status bits 7, 6, 5, 2, 1 and 0, the alarm registers, the match history and the square-wave state.
- R9: With calibration enable = 0, `irq_o` equals the OR of status bits 7, 6 and 5. With calibration enable = 1, `irq_o` is a square wave. It starts low, and it inverts at each edge where `cal_tick_i` is high and the calibration bit is already 1 before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| time_i | input | 8*NFIELD | Live BCD time; bits 7:0 seconds, 15:8 minutes, 23:16 hours |
| tick_i | input | 1 | One-cycle strobe once per second |
| wdog_expire_i | input | 1 | Watchdog expiry pulse |
| pwr_fail_i | input | 1 | Power-fail pulse |
| osc_fail_i | input | 1 | Oscillator-not-running indication from the power-up monitor |
| cal_tick_i | input | 1 | 512 Hz enable pulse for the calibration wave |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| status_o | output | 8 | Current status register |
| irq_o | output | 1 | Interrupt or calibration pin drive |

## Verification
The bench builds the block with its defaults, NFIELD = 3 and ADDR_W = 2. With these values all four addresses decode, the status register sits at the top address, and random writes reach every register, including ignore-bit and mode-bit combinations. Directed steps cover the cases that random traffic rarely hits. These are: a match that persists across ticks, an event in the same cycle as a status read, oscillator-fail held high during a clearing write, and the oscillator-fail flag kept across a mid-run reset. Random traffic then drives times close to the alarm values, so that matches begin and end often.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W = 8;

  localparam int BIT_WDF = 7;
  localparam int BIT_AF  = 6;
  localparam int BIT_PF  = 5;
  localparam int BIT_OSC = 4;
  localparam int BIT_CAL = 2;

  typedef struct packed {
    logic wdf;
    logic af;
    logic pf;
    logic osc;
    logic zero;
    logic cal;
    logic wen;
    logic ren;
  } status_t;

  // One field matches when ignored or when its 7 BCD bits are equal.
  function automatic logic field_ok(input logic [BYTE_W-1:0] areg,
                                    input logic [BYTE_W-1:0] tval);
    return areg[BYTE_W-1] | (areg[BYTE_W-2:0] == tval[BYTE_W-2:0]);
  endfunction

  // Next value of a sticky read-clear flag: the event beats the clear.
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic clr);
    return evt | (cur & ~clr);
  endfunction
endpackage

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int NFIELD = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NFIELD*BYTE_W-1:0] alarm_flat,
  input  logic [NFIELD*BYTE_W-1:0] time_flat,
  input  logic                     tick_i,
  output logic                     match_o,
  output logic                     event_o
);
  logic [NFIELD-1:0] ok;
  logic              prev_match_q;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign ok[g] = field_ok(alarm_flat[g*BYTE_W +: BYTE_W],
                            time_flat[g*BYTE_W +: BYTE_W]);
  end

  assign match_o = &ok;
  assign event_o = tick_i & match_o & ~prev_match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_match_q <= 1'b0;
    end else if (tick_i) begin
      prev_match_q <= match_o;
    end
  end
endmodule

// File: rtl/tod_flag_reg.sv
module tod_flag_reg
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdog_i,
  input  logic              alarm_i,
  input  logic              pwr_i,
  input  logic              osc_fail_i,
  input  logic              rd_clr_i,
  input  logic              wr_stat_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output status_t           status_o
);
  logic wdf_q, af_q, pf_q, osc_q, cal_q, wen_q, ren_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdf_q <= 1'b0;
      af_q  <= 1'b0;
      pf_q  <= 1'b0;
      cal_q <= 1'b0;
      wen_q <= 1'b0;
      ren_q <= 1'b0;
    end else begin
      wdf_q <= sticky_next(wdf_q, wdog_i, rd_clr_i);
      af_q  <= sticky_next(af_q, alarm_i, rd_clr_i);
      pf_q  <= sticky_next(pf_q, pwr_i, rd_clr_i);
      if (wr_stat_i) begin
        cal_q <= wdata_i[BIT_CAL];
        wen_q <= wdata_i[1];
        ren_q <= wdata_i[0];
      end
    end
  end

  // Retained flag: deliberately outside the power-up reset.
  always_ff @(posedge clk) begin
    if (osc_fail_i) begin
      osc_q <= 1'b1;
    end else if (wr_stat_i && !wdata_i[BIT_OSC]) begin
      osc_q <= 1'b0;
    end
  end

  always_comb begin
    status_o      = '0;
    status_o.wdf  = wdf_q;
    status_o.af   = af_q;
    status_o.pf   = pf_q;
    status_o.osc  = osc_q;
    status_o.zero = 1'b0;
    status_o.cal  = cal_q;
    status_o.wen  = wen_q;
    status_o.ren  = ren_q;
  end
endmodule

// File: rtl/tod_cal_wave.sv
module tod_cal_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic wave_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_o <= 1'b0;
    end else if (!en_i) begin
      wave_o <= 1'b0;
    end else if (tick_i) begin
      wave_o <= ~wave_o;
    end
  end
endmodule

// File: rtl/tod_alarm_status.sv
module tod_alarm_status
  import tod_alarm_pkg::*;
#(
  parameter int NFIELD = 3,
  parameter int ADDR_W = $clog2(NFIELD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NFIELD*BYTE_W-1:0] time_i,
  input  logic                     tick_i,
  input  logic                     wdog_expire_i,
  input  logic                     pwr_fail_i,
  input  logic                     osc_fail_i,
  input  logic                     cal_tick_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic [BYTE_W-1:0]        status_o,
  output logic                     irq_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NFIELD);

  logic [NFIELD*BYTE_W-1:0] alarm_flat;
  logic [BYTE_W-1:0]        alarm_q [NFIELD];
  status_t                  status;
  logic                     match_now;
  logic                     alarm_evt;
  logic                     rd_clr;
  logic                     wr_stat;
  logic                     cal_wave;

  assign rd_clr  = rd_en_i & (addr_i == STAT_ADDR);
  assign wr_stat = wr_en_i & (addr_i == STAT_ADDR);

  for (genvar g = 0; g < NFIELD; g++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_q[g] <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(g)) begin
        alarm_q[g] <= wdata_i;
      end
    end
    assign alarm_flat[g*BYTE_W +: BYTE_W] = alarm_q[g];
  end

  tod_alarm_match #(.NFIELD(NFIELD)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_flat (alarm_flat),
    .time_flat  (time_i),
    .tick_i     (tick_i),
    .match_o    (match_now),
    .event_o    (alarm_evt)
  );

  tod_flag_reg u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdog_i     (wdog_expire_i),
    .alarm_i    (alarm_evt),
    .pwr_i      (pwr_fail_i),
    .osc_fail_i (osc_fail_i),
    .rd_clr_i   (rd_clr),
    .wr_stat_i  (wr_stat),
    .wdata_i    (wdata_i),
    .status_o   (status)
  );

  tod_cal_wave u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (status.cal),
    .tick_i (cal_tick_i),
    .wave_o (cal_wave)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_ADDR) begin
      rdata_o = status;
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (addr_i == ADDR_W'(i)) rdata_o = alarm_q[i];
      end
    end
  end

  assign status_o = status;
  assign irq_o    = status.cal ? cal_wave : (status.wdf | status.af | status.pf);
endmodule

// File: rtl/tod_alarm_status_chk.sv
module tod_alarm_status_chk #(
  parameter int NFIELD = 3,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wdog_expire_i,
  input logic              pwr_fail_i,
  input logic              osc_fail_i,
  input logic              cal_tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        status_o,
  input logic              irq_o,
  input logic              alarm_evt,
  input logic              rd_clr
);
  logic wr_stat, osc_clear_wr;
  assign wr_stat      = wr_en_i && (addr_i == ADDR_W'(NFIELD));
  assign osc_clear_wr = wr_stat && !wdata_i[4];

  assert_wdf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |=> status_o[7]);
  assert_pf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> status_o[5]);
  assert_alarm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> status_o[6]);
  assert_alarm_only_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !$rose(status_o[6]));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wdog_expire_i) |=> !status_o[7]);
  assert_ro_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[5] && !pwr_fail_i) |=> !status_o[5]);
  assert_osc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_i |=> status_o[4]);
  assert_osc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !osc_clear_wr) |=> status_o[4]);
  assert_cal_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && cal_tick_i && !wr_stat) |=> (irq_o != $past(irq_o)));
endmodule

bind tod_alarm_status tod_alarm_status_chk #(.NFIELD(NFIELD), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .wdog_expire_i (wdog_expire_i),
  .pwr_fail_i    (pwr_fail_i),
  .osc_fail_i    (osc_fail_i),
  .cal_tick_i    (cal_tick_i),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .status_o      (status_o),
  .irq_o         (irq_o),
  .alarm_evt     (alarm_evt),
  .rd_clr        (rd_clr)
);

// File: tb/tod_alarm_status_test.sv
module tod_alarm_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [23:0]   time_i = '0;
  logic          tick_i = 0, wdog_expire_i = 0, pwr_fail_i = 0, osc_fail_i = 1;
  logic          cal_tick_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [1:0]    addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o, status_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [7:0] m_al [NF];
  logic m_prev, m_wdf, m_af, m_pf, m_osc, m_cal, m_w, m_r, m_sq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_status uut (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .tick_i(tick_i),
    .wdog_expire_i(wdog_expire_i), .pwr_fail_i(pwr_fail_i),
    .osc_fail_i(osc_fail_i), .cal_tick_i(cal_tick_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic alarm_hit(input logic [23:0] t);
    logic hit = 1'b1;
    for (int k = 0; k < NF; k++) begin
      if (m_al[k][7] == 1'b0 && m_al[k][6:0] != t[k*8 +: 7]) hit = 1'b0;
    end
    return hit;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_wdf, m_af, m_pf, m_osc, 1'b0, m_cal, m_w, m_r};
  endfunction

  function automatic logic [7:0] bcd(input int lim);
    int v = int'($urandom % lim);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // One bus/event cycle: drive at negedge, check read data, then check outputs after the edge.
  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input logic [1:0] a, input logic [7:0] d, input logic tk,
                     input logic wd, input logic pf, input logic ct);
    logic hit, ev, clr, nwdf, naf, npf, nosc, ncal, nw, nr, nsq;
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
    tick_i = tk; wdog_expire_i = wd; pwr_fail_i = pf; cal_tick_i = ct;
    #1;
    if (rd) chk({tag, " read"}, rdata_o, (a == 2'd3) ? m_status() : m_al[a]);
    hit = alarm_hit(time_i);
    ev  = tk && hit && !m_prev;
    clr = rd && a == 2'd3;
    nwdf = wd | (m_wdf & !clr);
    naf  = ev | (m_af & !clr);
    npf  = pf | (m_pf & !clr);
    nosc = osc_fail_i ? 1'b1 : ((wr && a == 2'd3 && !d[4]) ? 1'b0 : m_osc);
    ncal = (wr && a == 2'd3) ? d[2] : m_cal;
    nw   = (wr && a == 2'd3) ? d[1] : m_w;
    nr   = (wr && a == 2'd3) ? d[0] : m_r;
    nsq  = !m_cal ? 1'b0 : (ct ? ~m_sq : m_sq);
    @(posedge clk);
    #1;
    if (tk) m_prev = hit;
    if (wr && a != 2'd3) m_al[a] = d;
    m_wdf = nwdf; m_af = naf; m_pf = npf; m_osc = nosc;
    m_cal = ncal; m_w = nw; m_r = nr; m_sq = nsq;
    chk({tag, " status"}, status_o, m_status());
    chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, m_cal ? m_sq : (m_wdf | m_af | m_pf)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en_i = 0; rd_en_i = 0; tick_i = 0; wdog_expire_i = 0; pwr_fail_i = 0; cal_tick_i = 0;
    repeat (2) @(negedge clk);
    if (osc_fail_i) m_osc = 1'b1;
    rst_n = 1'b1;
    for (int k = 0; k < NF; k++) m_al[k] = 8'h00;
    m_prev = 0; m_wdf = 0; m_af = 0; m_pf = 0; m_cal = 0; m_w = 0; m_r = 0; m_sq = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    void'($urandom(32'd2024));
    m_osc = 1'b1;
    do_reset();
    osc_fail_i = 1'b0;
    #1;
    // R8 R7: reset state, retained oscillator flag set by power-up indication
    chk("R8 reset status", status_o, 8'h10);
    chk("R8 reset irq", {7'd0, irq_o}, 8'h00);
    for (int k = 0; k < NF; k++) begin
      addr_i = 2'(k); #1;
      chk("R1 R8 reset alarm", rdata_o, 8'h00);
    end

    // R1: program and read back alarm 09:15:30
    cyc("R1", 1, 0, 2'd0, 8'h30, 0, 0, 0, 0);
    cyc("R1", 1, 0, 2'd1, 8'h15, 0, 0, 0, 0);
    cyc("R1", 1, 0, 2'd2, 8'h09, 0, 0, 0, 0);
    for (int k = 0; k < NF; k++) cyc("R1", 0, 1, 2'(k), 8'h00, 0, 0, 0, 0);
    cyc("R7 clear osc", 1, 0, 2'd3, 8'h00, 0, 0, 0, 0);
    chk("R7 osc cleared by write 0", status_o, 8'h00);

    // R2 R3: near miss, then exact match on tick
    time_i = 24'h091529;
    cyc("R2 miss", 0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    chk("R2 no alarm on mismatch", status_o, 8'h00);
    time_i = 24'h091530;
    cyc("R3 no tick", 0, 0, 2'd0, 8'h00, 0, 0, 0, 0);
    chk("R3 no alarm without tick", status_o, 8'h00);
    cyc("R2 hit", 0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    chk("R2 alarm on match", status_o, 8'h40);
    chk("R9 irq from alarm", {7'd0, irq_o}, 8'h01);
    cyc("R6 read", 0, 1, 2'd3, 8'h00, 0, 0, 0, 0);
    chk("R6 read clears alarm", status_o, 8'h00);
    cyc("R3 persist", 0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    chk("R3 persistent match no refire", status_o, 8'h00);

    // R2: ignore the seconds field, match on minutes and hours
    time_i = 24'h091600;
    cyc("R2 break", 0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    cyc("R2 mask", 1, 0, 2'd0, 8'hB0, 0, 0, 0, 0);
    time_i = 24'h091547;
    cyc("R2 masked hit", 0, 0, 2'd0, 8'h00, 1, 0, 0, 0);
    chk("R2 ignored seconds field", status_o, 8'h40);

    // R6: event in the same cycle as the clearing read wins
    cyc("R6 race", 0, 1, 2'd3, 8'h00, 0, 1, 0, 0);
    chk("R6 event beats read clear", status_o, 8'h80);
    cyc("R5 pf", 0, 0, 2'd0, 8'h00, 0, 0, 1, 0);
    chk("R5 power fail sticky", status_o, 8'hA0);

    // R4 R7: write all ones; read-only bits and osc bit unaffected
    cyc("R6 clear", 0, 1, 2'd3, 8'h00, 0, 0, 0, 0);
    cyc("R4 write ff", 1, 0, 2'd3, 8'hFF, 0, 0, 0, 0);
    chk("R4 R7 read-only bits ignore write", status_o, 8'h07);

    // R9: calibration wave
    cyc("R9 cal", 0, 0, 2'd0, 8'h00, 0, 0, 0, 1);
    chk("R9 wave high after first tick", {7'd0, irq_o}, 8'h01);
    cyc("R9 cal", 0, 0, 2'd0, 8'h00, 0, 0, 0, 0);
    chk("R9 wave holds", {7'd0, irq_o}, 8'h01);
    cyc("R9 cal", 0, 0, 2'd0, 8'h00, 0, 0, 0, 1);
    chk("R9 wave low after second tick", {7'd0, irq_o}, 8'h00);
    cyc("R9 cal wd", 0, 0, 2'd0, 8'h00, 0, 1, 0, 0);
    chk("R9 flags hidden during cal", {7'd0, irq_o}, 8'h00);
    cyc("R9 cal off", 1, 0, 2'd3, 8'h00, 0, 0, 0, 0);
    chk("R9 normal irq restored", {7'd0, irq_o}, 8'h01);

    // R7: clearing write while osc_fail_i held high; flag retained across reset
    osc_fail_i = 1'b1;
    cyc("R7 held", 1, 0, 2'd3, 8'h00, 0, 0, 0, 0);
    chk("R7 set wins over clear", status_o & 8'h10, 8'h10);
    osc_fail_i = 1'b0;
    cyc("R7 idle", 0, 0, 2'd0, 8'h00, 0, 0, 0, 0);
    do_reset();
    #1;
    chk("R7 R8 osc survives reset", status_o, 8'h10);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, rd, tk, wd, pf, ct;
      logic [1:0] a;
      r = 8'($urandom % 100);
      wr = r < 8;
      rd = !wr && r < 20;
      a  = (rd && ($urandom % 2)) ? 2'd3 : 2'($urandom % 4);
      tk = ($urandom % 100) < 30;
      wd = ($urandom % 100) < 3;
      pf = ($urandom % 100) < 3;
      ct = ($urandom % 100) < 20;
      osc_fail_i = ($urandom % 100) < 2;
      for (int k = 0; k < NF; k++) begin
        if ($urandom % 2) time_i[k*8 +: 8] = {1'b0, m_al[k][6:0]};
        else time_i[k*8 +: 8] = bcd((k == 2) ? 24 : 60);
      end
      cyc("R2 R3 R5 R6 random", wr, rd, a, wr ? 8'($urandom) : 8'h00, tk, wd, pf, ct);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule